// File: doc/BRIEF.md
# PCI Target Transaction Controller

This block sequences one PCI target transaction at a time. It follows the bus framing signals to find address phases, both for its own cycles and for those of other agents. When the address decoder reports a hit, it claims the cycle with medium decode timing. It then paces each data phase from the fill level that the local buffer reports, and ends the cycle in one of three ways: a normal completion, a disconnect (with or without data), or a target abort.

The bus-facing strobes leave the block as registered active-low values, plus one shared output enable. The datapath receives four enables. The first loads the address register in the address phase. The second lets the target drive AD for reads, and only after the turnaround clock. The third pushes each write word that the bus accepts. The fourth pops each read word that the bus accepts.

Top module: `pci_tgt_ctrl`

## Requirements
- R1: After reset, devsel_no, trdy_no and stop_no are high, and ctl_oe_o and ad_oe_o are low.
- R2: addr_le_o is high only in a clock where frame_ni is low and the bus was idle at the previous edge (frame_ni and irdy_ni both high). It stays low during the later phases of any transaction.
- R3: hit_i is sampled at the first edge after the address edge. A hit drives devsel_no low from that edge onward. The address edge itself never asserts devsel_no.
- R4: ad_oe_o is asserted only for read commands (rd_cmd_i high at the address edge). It is never asserted at the address edge, so a full turnaround clock passes first. It drops at the edge that ends the last data phase.
- R5: A word moves in every clock in which the cycle is claimed and both irdy_ni and trdy_no are low. That clock pulses wr_push_o for writes and rd_pop_o for reads. While the initiator waits, the asserted trdy_no holds.
- R6: The level of the selected direction (rd_lvl_i for reads, wr_lvl_i for writes) means 0 = none, 1 = exactly one, 2 or more = several words or slots for the coming phase. If the level is 1 or more, trdy_no goes low. A level of 1 with frame_ni high (final phase) gives no stop.
- R7: A level of 1 while frame_ni is still low asserts trdy_no and stop_no together (disconnect with data). After that word moves, trdy_no goes high while stop_no stays low.
- R8: A level of 0 asserts stop_no with trdy_no high (disconnect without data).
- R9: Once asserted, stop_no stays low until an edge that sees frame_ni high and irdy_ni low.
- R10: When fatal_i is high during a claimed data phase, the block ends with a target abort. stop_no goes low, devsel_no goes high and trdy_no goes high, all at the same edge.
- R11: After the edge that ends the last data phase, devsel_no, trdy_no and stop_no are driven high for one clock with ctl_oe_o high. Then ctl_oe_o falls.
- R12: In a cycle that is not claimed, the strobes and enables stay idle for the whole transaction, whatever hit_i does after the decode edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | bus clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| frame_ni | input | 1 | framing strobe from the bus, active low |
| irdy_ni | input | 1 | initiator ready from the bus, active low |
| hit_i | input | 1 | decoder hit on a memory or I/O base, valid at the edge after the address edge |
| rd_cmd_i | input | 1 | current command is a read, valid at the address edge |
| rd_lvl_i | input | LVL_W | read words available for the coming phase |
| wr_lvl_i | input | LVL_W | write slots free for the coming phase |
| fatal_i | input | 1 | unrecoverable local error, abort request |
| devsel_no | output | 1 | device select, active low |
| trdy_no | output | 1 | target ready, active low |
| stop_no | output | 1 | stop request, active low |
| ctl_oe_o | output | 1 | output enable for the three target strobes |
| ad_oe_o | output | 1 | output enable for read data on AD |
| addr_le_o | output | 1 | address register load enable |
| wr_push_o | output | 1 | write word accepted this clock |
| rd_pop_o | output | 1 | read word accepted this clock |

## Verification
The bench builds the block with the default LVL_W of 2, so a level can be 0, 1, or saturated at 2 or more. Driving levels of 0, 1 and 3 reaches every pacing branch: disconnect without data, disconnect with data, the final single word, and an open burst. A two-bit level keeps every branch reachable in a few clocks of directed stimulus. The initiator side is scripted clock by clock, so wait states, a foreign transaction with a stray hit, and an abort after a transfer each land on a known edge.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DEC,
    ST_XFER,
    ST_OFF
  } tgt_st_e;

  // asserted-high view of the target strobes and enables
  typedef struct packed {
    logic devsel;
    logic trdy;
    logic stop;
    logic ctl_oe;
    logic ad_oe;
  } strobe_t;

endpackage

// File: rtl/pci_bus_track.sv
module pci_bus_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_ni,
  input  logic irdy_ni,
  output logic addr_ph_o
);

  logic idle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idle_q <= 1'b1;
    else         idle_q <= frame_ni & irdy_ni;
  end

  assign addr_ph_o = idle_q & ~frame_ni;

  // R2
  addr_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_ph_o |=> !addr_ph_o);

endmodule

// File: rtl/pci_tgt_fsm.sv
module pci_tgt_fsm
  import pci_tgt_pkg::*;
#(
  parameter int unsigned LVL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             addr_ph_i,
  input  logic             frame_ni,
  input  logic             irdy_ni,
  input  logic             hit_i,
  input  logic             rd_cmd_i,
  input  logic [LVL_W-1:0] rd_lvl_i,
  input  logic [LVL_W-1:0] wr_lvl_i,
  input  logic             fatal_i,
  input  strobe_t          cur_i,
  output strobe_t          nxt_o,
  output logic             rd_q_o,
  output logic             xfer_o
);

  localparam logic [LVL_W-1:0] LVL_NONE = '0;
  localparam logic [LVL_W-1:0] LVL_ONE  = LVL_W'(1);

  tgt_st_e          st_q, st_d;
  logic             rd_q;
  logic [LVL_W-1:0] lvl;
  logic             xfer, fin;
  logic [1:0]       pace;  // {trdy, stop}

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      rd_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && addr_ph_i) rd_q <= rd_cmd_i;
    end
  end

  assign lvl  = rd_q ? rd_lvl_i : wr_lvl_i;
  assign xfer = (st_q == ST_XFER) & cur_i.trdy & ~irdy_ni;
  // last phase completes: initiator done and target answered with data or stop
  assign fin  = (st_q == ST_XFER) & frame_ni & ~irdy_ni & (cur_i.trdy | cur_i.stop);

  always_comb begin
    if (lvl == LVL_NONE)     pace = 2'b01;
    else if (lvl == LVL_ONE) pace = {1'b1, ~frame_ni};
    else                     pace = 2'b10;
  end

  always_comb begin
    st_d  = st_q;
    nxt_o = cur_i;
    unique case (st_q)
      ST_IDLE: begin
        nxt_o = '0;
        if (addr_ph_i) st_d = ST_DEC;
      end
      ST_DEC: begin
        nxt_o = '0;
        if (hit_i) begin
          st_d         = ST_XFER;
          nxt_o.devsel = 1'b1;
          nxt_o.ctl_oe = 1'b1;
          nxt_o.ad_oe  = rd_q;
          {nxt_o.trdy, nxt_o.stop} = pace;
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_XFER: begin
        if (fin) begin
          st_d   = ST_OFF;
          nxt_o  = '0;
          nxt_o.ctl_oe = 1'b1;
        end else if (cur_i.stop) begin
          if (xfer) nxt_o.trdy = 1'b0;
        end else if (fatal_i) begin
          nxt_o.devsel = 1'b0;
          nxt_o.trdy   = 1'b0;
          nxt_o.stop   = 1'b1;
        end else if (xfer) begin
          {nxt_o.trdy, nxt_o.stop} = pace;
        end
      end
      ST_OFF: begin
        st_d  = ST_IDLE;
        nxt_o = '0;
      end
      default: begin
        st_d  = ST_IDLE;
        nxt_o = '0;
      end
    endcase
  end

  assign rd_q_o = rd_q;
  assign xfer_o = xfer;

  // R12
  miss_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DEC && !hit_i) |=> (st_q == ST_IDLE));

  // R11
  off_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_OFF) |=> (st_q == ST_IDLE));

endmodule

// File: rtl/pci_tgt_drv.sv
module pci_tgt_drv
  import pci_tgt_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  strobe_t nxt_i,
  output strobe_t cur_o,
  output logic    devsel_no,
  output logic    trdy_no,
  output logic    stop_no,
  output logic    ctl_oe_o,
  output logic    ad_oe_o
);

  strobe_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= nxt_i;
  end

  assign cur_o     = q;
  assign devsel_no = ~q.devsel;
  assign trdy_no   = ~q.trdy;
  assign stop_no   = ~q.stop;
  assign ctl_oe_o  = q.ctl_oe;
  assign ad_oe_o   = q.ad_oe;

endmodule

// File: rtl/pci_tgt_ctrl.sv
module pci_tgt_ctrl
  import pci_tgt_pkg::*;
#(
  parameter int unsigned LVL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_ni,
  input  logic             irdy_ni,
  input  logic             hit_i,
  input  logic             rd_cmd_i,
  input  logic [LVL_W-1:0] rd_lvl_i,
  input  logic [LVL_W-1:0] wr_lvl_i,
  input  logic             fatal_i,
  output logic             devsel_no,
  output logic             trdy_no,
  output logic             stop_no,
  output logic             ctl_oe_o,
  output logic             ad_oe_o,
  output logic             addr_le_o,
  output logic             wr_push_o,
  output logic             rd_pop_o
);

  logic    addr_ph, rd_q, xfer;
  strobe_t nxt, cur;

  pci_bus_track u_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .frame_ni  (frame_ni),
    .irdy_ni   (irdy_ni),
    .addr_ph_o (addr_ph)
  );

  pci_tgt_fsm #(.LVL_W(LVL_W)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_ph_i (addr_ph),
    .frame_ni  (frame_ni),
    .irdy_ni   (irdy_ni),
    .hit_i     (hit_i),
    .rd_cmd_i  (rd_cmd_i),
    .rd_lvl_i  (rd_lvl_i),
    .wr_lvl_i  (wr_lvl_i),
    .fatal_i   (fatal_i),
    .cur_i     (cur),
    .nxt_o     (nxt),
    .rd_q_o    (rd_q),
    .xfer_o    (xfer)
  );

  pci_tgt_drv u_drv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .nxt_i     (nxt),
    .cur_o     (cur),
    .devsel_no (devsel_no),
    .trdy_no   (trdy_no),
    .stop_no   (stop_no),
    .ctl_oe_o  (ctl_oe_o),
    .ad_oe_o   (ad_oe_o)
  );

  assign addr_le_o = addr_ph;
  assign wr_push_o = xfer & ~rd_q;
  assign rd_pop_o  = xfer &  rd_q;

  // R3
  no_fast_claim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_le_o |=> devsel_no);

  // R6
  trdy_claimed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trdy_no |-> !devsel_no);

  // R9
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stop_no && !(frame_ni && !irdy_ni)) |=> !stop_no);

  // R11
  release_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctl_oe_o) |-> $past(devsel_no && trdy_no && stop_no));

  // R4
  ad_read_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ad_oe_o |-> !wr_push_o);

  // R5
  one_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_pop_o, wr_push_o}));

  // R10
  abort_no_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stop_no && devsel_no) |-> trdy_no);

endmodule

// File: tb/pci_tgt_ctrl_test.sv
module pci_tgt_ctrl_test;

  localparam int unsigned LVL_W = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic frame_ni = 1'b1, irdy_ni = 1'b1, hit_i = 1'b0, rd_cmd_i = 1'b0, fatal_i = 1'b0;
  logic [LVL_W-1:0] rd_lvl_i = '0, wr_lvl_i = '0;
  logic devsel_no, trdy_no, stop_no, ctl_oe_o, ad_oe_o, addr_le_o, wr_push_o, rd_pop_o;
  logic [4:0] pins;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  pci_tgt_ctrl #(.LVL_W(LVL_W)) uut (.*);

  // {ctl_oe, ad_oe, devsel_n, trdy_n, stop_n}
  assign pins = {ctl_oe_o, ad_oe_o, devsel_no, trdy_no, stop_no};

  localparam logic [4:0] P_IDLE = 5'b00111, P_OFF = 5'b10111;

  task automatic step();
    @(posedge clk_i); #2;
  endtask

  task automatic chk(input string req, input logic [4:0] exp);
    n_run++;
    if (pins !== exp) begin
      n_fail++;
      $display("FAIL %s strobes act=%b exp=%b", req, pins, exp);
    end
  endtask

  task automatic chk1(input string req, input string nm, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%b exp=%b", req, nm, act, exp);
    end
  endtask

  task automatic addr(input logic rd);
    frame_ni = 1'b0; irdy_ni = 1'b1; rd_cmd_i = rd; hit_i = 1'b0; #1;
    chk1("R2", "addr_le", addr_le_o, 1'b1);
    step();
    chk("R3", P_IDLE);   // no claim and no AD drive at the address edge (R4)
  endtask

  task automatic finish_off(input string req);
    frame_ni = 1'b1; irdy_ni = 1'b0; hit_i = 1'b0;
    step();
    chk(req, P_OFF);
    irdy_ni = 1'b1;
    step();
    chk("R11", P_IDLE);
  endtask

  task automatic t_reset();
    chk("R1", P_IDLE);
    chk1("R1", "addr_le", addr_le_o, 1'b0);
  endtask

  task automatic t_write_burst();
    addr(1'b0);
    hit_i = 1'b1; irdy_ni = 1'b0; wr_lvl_i = 2'd3;
    step(); chk("R3", 5'b10001);
    hit_i = 1'b0; #1;
    chk1("R5", "wr_push", wr_push_o, 1'b1);
    chk1("R5", "rd_pop", rd_pop_o, 1'b0);
    step(); chk("R6", 5'b10001);
    chk1("R5", "wr_push", wr_push_o, 1'b1);
    step();
    chk1("R2", "addr_le", addr_le_o, 1'b0);
    finish_off("R11");
  endtask

  task automatic t_read_burst();
    addr(1'b1);
    hit_i = 1'b1; irdy_ni = 1'b0; rd_lvl_i = 2'd3;
    step(); chk("R4", 5'b11001);
    hit_i = 1'b0; #1;
    chk1("R5", "rd_pop", rd_pop_o, 1'b1);
    step(); chk("R5", 5'b11001);
    finish_off("R4");
  endtask

  task automatic t_foreign();
    frame_ni = 1'b0; irdy_ni = 1'b1; rd_cmd_i = 1'b0; hit_i = 1'b0;
    step(); chk("R12", P_IDLE);
    irdy_ni = 1'b0;
    step(); chk("R12", P_IDLE);
    hit_i = 1'b1;   // stray hit while not addressed
    for (int i = 0; i < 3; i++) begin
      #1; chk1("R2", "addr_le", addr_le_o, 1'b0);
      step(); chk("R12", P_IDLE);
    end
    frame_ni = 1'b1;
    step(); chk("R12", P_IDLE);
    chk1("R12", "wr_push", wr_push_o, 1'b0);
    irdy_ni = 1'b1; hit_i = 1'b0;
    step(); chk("R12", P_IDLE);
  endtask

  task automatic t_disc_data();
    addr(1'b0);
    hit_i = 1'b1; irdy_ni = 1'b0; wr_lvl_i = 2'd1;
    step(); chk("R7", 5'b10000);
    hit_i = 1'b0; wr_lvl_i = 2'd0; #1;
    chk1("R7", "wr_push", wr_push_o, 1'b1);
    step(); chk("R7", 5'b10010);
    chk1("R9", "wr_push", wr_push_o, 1'b0);
    step(); chk("R9", 5'b10010);
    finish_off("R9");
  endtask

  task automatic t_disc_nodata();
    addr(1'b1);
    hit_i = 1'b1; irdy_ni = 1'b0; rd_lvl_i = 2'd0;
    step(); chk("R8", 5'b11010);
    hit_i = 1'b0; #1;
    chk1("R8", "rd_pop", rd_pop_o, 1'b0);
    step(); chk("R9", 5'b11010);
    finish_off("R8");
  endtask

  task automatic t_abort();
    addr(1'b0);
    hit_i = 1'b1; irdy_ni = 1'b0; wr_lvl_i = 2'd3;
    step(); chk("R10", 5'b10001);
    hit_i = 1'b0; fatal_i = 1'b1;
    step(); chk("R10", 5'b10110);
    chk1("R10", "wr_push", wr_push_o, 1'b0);
    fatal_i = 1'b0;
    step(); chk("R9", 5'b10110);
    finish_off("R10");
  endtask

  task automatic t_wait_read();
    addr(1'b1);
    hit_i = 1'b1; irdy_ni = 1'b1; rd_lvl_i = 2'd2;
    step(); chk("R6", 5'b11001);
    hit_i = 1'b0; #1;
    chk1("R5", "rd_pop", rd_pop_o, 1'b0);
    step(); chk("R5", 5'b11001);
    irdy_ni = 1'b0; rd_lvl_i = 2'd1; #1;
    chk1("R5", "rd_pop", rd_pop_o, 1'b1);
    step(); chk("R7", 5'b11000);
    frame_ni = 1'b1; #1;
    chk1("R7", "rd_pop", rd_pop_o, 1'b1);
    step(); chk("R7", P_OFF);
    irdy_ni = 1'b1;
    step(); chk("R11", P_IDLE);
  endtask

  task automatic t_single_write();
    addr(1'b0);
    hit_i = 1'b1; frame_ni = 1'b1; irdy_ni = 1'b0; wr_lvl_i = 2'd1;
    step(); chk("R6", 5'b10001);
    hit_i = 1'b0; #1;
    chk1("R6", "wr_push", wr_push_o, 1'b1);
    step(); chk("R11", P_OFF);
    irdy_ni = 1'b1;
    step(); chk("R11", P_IDLE);
  endtask

  initial begin
    #3;
    t_reset();
    rst_ni = 1'b1;
    step(); step();
    t_reset();
    t_write_burst();
    t_read_burst();
    t_foreign();
    t_write_burst();
    t_disc_data();
    t_disc_nodata();
    t_abort();
    t_wait_read();
    t_single_write();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule